// File: doc/BRIEF.md
# Calendar Alarm Match Unit

This unit watches a running calendar, which is supplied from outside as packed BCD fields for seconds, minutes, hours, day of month, month and a three-digit year, and raises a level interrupt when the calendar reaches a programmed alarm. Six alarm registers hold the target value for each field. A control register holds one compare-enable bit per field and a master enable. The calendar counter owns the one-second strobe. In the cycle that the strobe is high, the time inputs already show the newly advanced second.

The match rule is permissive. When the master enable is set, the alarm fires if any single enabled field equals its alarm register. It does not wait for all enabled fields to agree. A fire sets a sticky pending flag, and that flag drives the interrupt line. Software reads the flag through the register port and clears it by writing a one to its bit.

Top module: `rtc_alarm_cmp`

## Requirements
- R1: After reset every register (addresses 0 to 7) reads as zero and `alarm_irq` is low.
- R2: Alarm values are masked when written. Seconds (address 2) and minutes (address 3) keep 7 bits, hours (address 4) and day (address 5) keep 6 bits, month (address 6) keeps 5 bits and year (address 7) keeps 12 bits. A read returns the stored value.
- R3: Control register (address 0) bits 0 to 5 enable the compare of seconds, minutes, hours, day, month and year, in that order. Bit 6 is the master enable. Only these 7 bits are stored.
- R4: While control bit 6 is clear, no fire occurs, even when enabled fields match.
- R5: A single enabled field that matches fires the alarm, even when other enabled fields differ.
- R6: A field whose enable bit is clear never causes a fire, whatever its value.
- R7: The compare is made only in a cycle where `sec_tick` is high. A matching calendar without the strobe causes no fire.
- R8: A fire on a strobe sampled at clock edge N sets pending bit 1 of the pending register (address 1) and drives `alarm_irq` high from edge N onward.
- R9: `alarm_irq` stays high after a fire, across later strobes with no match, until software clears it.
- R10: Writing address 1 with bit 1 set clears the pending flag and drops `alarm_irq`. A write with bit 1 clear has no effect, whatever the other bits hold.
- R11: When a fire and a clearing write happen in the same cycle, the fire wins and `alarm_irq` stays high.
- R12: The year compare covers all 12 bits: two BCD digits in bits 7:0 and the hundreds digit in bits 11:8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address, used for both reads and writes |
| wdata | input | 12 | Register write data |
| rdata | output | 12 | Read data for `addr`, combinational |
| sec_tick | input | 1 | One-second strobe, high for one cycle after the calendar advances |
| cur_sec | input | 7 | Current seconds, BCD |
| cur_min | input | 7 | Current minutes, BCD |
| cur_hour | input | 6 | Current hours, BCD |
| cur_day | input | 6 | Current day of month, BCD |
| cur_mon | input | 5 | Current month, BCD |
| cur_year | input | 12 | Current year, three BCD digits |
| alarm_irq | output | 1 | Alarm interrupt, a level held until cleared |

## Verification
The assertions assume that `sec_tick` is a single-cycle pulse and that the time inputs are stable and valid during that cycle. They also assume that a write is a one-cycle `wr_en` with `addr` and `wdata` held steady. The bench changes the time fields and the register port only at falling edges. It raises the strobe for exactly one cycle at a time, and it never drives a value wider than the field it targets. The only case where the strobe and a write overlap is the deliberate fire-against-clear collision.

// File: rtl/rtc_alarm_pkg.sv
// Package: rtc_alarm_pkg
// Shared constants for the calendar alarm match unit: field count, field
// widths, register addresses and the bit positions that have a meaning.
package rtc_alarm_pkg;

    localparam int NUM_FIELDS = 6;
    localparam int FIELD_W    = 12;
    localparam int ADDR_W     = 3;
    localparam int CTRL_W     = NUM_FIELDS + 1;
    localparam int MASTER_BIT = NUM_FIELDS;
    localparam int PEND_BIT   = 1;

    localparam int SEC_W  = 7;
    localparam int MIN_W  = 7;
    localparam int HOUR_W = 6;
    localparam int DAY_W  = 6;
    localparam int MON_W  = 5;
    localparam int YEAR_W = 12;

    typedef enum logic [ADDR_W-1:0] {
        RA_CTRL = 3'd0,
        RA_PEND = 3'd1,
        RA_SEC  = 3'd2,
        RA_MIN  = 3'd3,
        RA_HOUR = 3'd4,
        RA_DAY  = 3'd5,
        RA_MON  = 3'd6,
        RA_YEAR = 3'd7
    } reg_addr_e;

    // Stored width of field idx, where 0 is seconds and 5 is year.
    function automatic int field_bits(input int idx);
        case (idx)
            0, 1:    return SEC_W;
            2, 3:    return HOUR_W;
            4:       return MON_W;
            default: return YEAR_W;
        endcase
    endfunction

endpackage

// File: rtl/rtc_alarm_regs.sv
// Module: rtc_alarm_regs
// Holds the alarm control register and the six alarm value registers.
// Each value is masked to its field width when written (R2). The control
// register keeps seven bits (R3). Assumes that a write is a one-cycle
// wr_en with addr and wdata valid in that cycle.
module rtc_alarm_regs
    import rtc_alarm_pkg::*;
(
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               wr_en,
    input  logic [ADDR_W-1:0]                  addr,
    input  logic [FIELD_W-1:0]                 wdata,
    output logic [CTRL_W-1:0]                  ctrl_q,
    output logic [NUM_FIELDS-1:0][FIELD_W-1:0] alm_q
);

    // Control register: compare enables and the master enable.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= '0;
        else if (wr_en && addr == RA_CTRL)
            ctrl_q <= wdata[CTRL_W-1:0];
    end

    // One masked value register per field.
    for (genvar gi = 0; gi < NUM_FIELDS; gi++) begin : g_field
        localparam int                  FB    = field_bits(gi);
        localparam logic [FIELD_W-1:0]  MASK  = FIELD_W'((1 << FB) - 1);
        localparam logic [ADDR_W-1:0]   MY_AD = ADDR_W'(int'(RA_SEC) + gi);

        // Store the masked write value when this field's address is hit.
        always_ff @(posedge clk) begin
            if (!rst_n)
                alm_q[gi] <= '0;
            else if (wr_en && addr == MY_AD)
                alm_q[gi] <= wdata & MASK;
        end
    end

endmodule

// File: rtl/rtc_alarm_match.sv
// Module: rtc_alarm_match
// Purely combinational compare of each enabled alarm field against the
// current calendar field. The results are ORed into one hit (R5, R6).
// Assumes that both operands are zero-extended to FIELD_W bits.
module rtc_alarm_match
    import rtc_alarm_pkg::*;
(
    input  logic [NUM_FIELDS-1:0]              field_en,
    input  logic [NUM_FIELDS-1:0][FIELD_W-1:0] alm_val,
    input  logic [NUM_FIELDS-1:0][FIELD_W-1:0] cur_val,
    output logic [NUM_FIELDS-1:0]              field_hit,
    output logic                               any_hit
);

    // Compare each field over the full width, so the year hundreds digit counts (R12).
    for (genvar gi = 0; gi < NUM_FIELDS; gi++) begin : g_cmp
        assign field_hit[gi] = field_en[gi] && (alm_val[gi] == cur_val[gi]);
    end

    // A hit on any enabled field is enough.
    assign any_hit = |field_hit;

endmodule

// File: rtl/rtc_alarm_pend.sv
// Module: rtc_alarm_pend
// Sticky alarm-pending flag. A fire sets it. A write-one-to-clear resets
// it. A fire takes priority over a clear in the same cycle (R11).
// Assumes that fire and clr are single-cycle qualified strobes.
module rtc_alarm_pend (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    input  logic clr,
    output logic pend_q
);

    // Set on a fire, otherwise clear on request, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend_q <= 1'b0;
        else if (fire)
            pend_q <= 1'b1;
        else if (clr)
            pend_q <= 1'b0;
    end

endmodule

// File: rtl/rtc_alarm_cmp.sv
// Module: rtc_alarm_cmp
// Top level of the calendar alarm match unit. It wires the register file,
// the field matcher and the pending flag together, and drives the read
// mux. Assumes that sec_tick is a one-cycle pulse, given once the calendar
// inputs show the new second. The calendar counter is outside this block.
module rtc_alarm_cmp
    import rtc_alarm_pkg::*;
#(
    parameter int DATA_W = FIELD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              sec_tick,
    input  logic [SEC_W-1:0]  cur_sec,
    input  logic [MIN_W-1:0]  cur_min,
    input  logic [HOUR_W-1:0] cur_hour,
    input  logic [DAY_W-1:0]  cur_day,
    input  logic [MON_W-1:0]  cur_mon,
    input  logic [YEAR_W-1:0] cur_year,
    output logic              alarm_irq
);

    logic [CTRL_W-1:0]                  ctrl_q;
    logic [NUM_FIELDS-1:0][FIELD_W-1:0] alm_q;
    logic [NUM_FIELDS-1:0][FIELD_W-1:0] cur_val;
    logic [NUM_FIELDS-1:0]              field_hit;
    logic                               any_hit;
    logic                               fire;
    logic                               clr;
    logic                               pend_q;

    rtc_alarm_regs u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .addr   (addr),
        .wdata  (wdata[FIELD_W-1:0]),
        .ctrl_q (ctrl_q),
        .alm_q  (alm_q)
    );

    // Zero-extend the calendar fields into the matcher's common width.
    always_comb begin
        cur_val[0] = FIELD_W'(cur_sec);
        cur_val[1] = FIELD_W'(cur_min);
        cur_val[2] = FIELD_W'(cur_hour);
        cur_val[3] = FIELD_W'(cur_day);
        cur_val[4] = FIELD_W'(cur_mon);
        cur_val[5] = FIELD_W'(cur_year);
    end

    rtc_alarm_match u_match (
        .field_en  (ctrl_q[NUM_FIELDS-1:0]),
        .alm_val   (alm_q),
        .cur_val   (cur_val),
        .field_hit (field_hit),
        .any_hit   (any_hit)
    );

    // Fire only on the strobe, with the master enable set (R4, R7).
    assign fire = sec_tick && ctrl_q[MASTER_BIT] && any_hit;
    // Clear only by a write that has the pending bit set (R10).
    assign clr  = wr_en && (addr == RA_PEND) && wdata[PEND_BIT];

    rtc_alarm_pend u_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .fire   (fire),
        .clr    (clr),
        .pend_q (pend_q)
    );

    assign alarm_irq = pend_q;

    // Read mux: control, pending flag at its fixed bit, or an alarm value.
    always_comb begin
        rdata = '0;
        case (addr)
            RA_CTRL: rdata = DATA_W'(ctrl_q);
            RA_PEND: rdata = DATA_W'({pend_q, {PEND_BIT{1'b0}}});
            default: rdata = DATA_W'(alm_q[addr - RA_SEC]);
        endcase
    end

endmodule

// File: rtl/rtc_alarm_chk.sv
// Module: rtc_alarm_chk
// Timing properties of the alarm unit, attached to the top with bind.
// Assumes a one-cycle sec_tick and one-cycle register writes.
module rtc_alarm_chk
    import rtc_alarm_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                wr_en,
    input logic [ADDR_W-1:0]   addr,
    input logic [FIELD_W-1:0]  wdata,
    input logic                sec_tick,
    input logic                alarm_irq,
    input logic [CTRL_W-1:0]   ctrl_q,
    input logic                any_hit
);

    logic c_fire;
    logic c_clr;
    assign c_fire = sec_tick && ctrl_q[MASTER_BIT] && any_hit;
    assign c_clr  = wr_en && addr == RA_PEND && wdata[PEND_BIT];

    p_fire_sets_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
        c_fire |=> alarm_irq);

    p_rise_needs_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alarm_irq) |-> $past(sec_tick));

    p_rise_needs_master_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alarm_irq) |-> $past(ctrl_q[MASTER_BIT]));

    p_level_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_irq && !c_clr) |=> alarm_irq);

    p_clear_drops_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (c_clr && !c_fire) |=> !alarm_irq);

    p_hit_needs_enable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        any_hit |-> (ctrl_q[NUM_FIELDS-1:0] != '0));

endmodule

bind rtc_alarm_cmp rtc_alarm_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .addr      (addr),
    .wdata     (wdata[rtc_alarm_pkg::FIELD_W-1:0]),
    .sec_tick  (sec_tick),
    .alarm_irq (alarm_irq),
    .ctrl_q    (ctrl_q),
    .any_hit   (any_hit)
);

// File: tb/sim_rtc_alarm_cmp.sv
// Directed bench for rtc_alarm_cmp: one task per scenario.
module sim_rtc_alarm_cmp;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [11:0] wdata = '0;
    logic [11:0] rdata;
    logic        sec_tick = 1'b0;
    logic [6:0]  cur_sec = '0;
    logic [6:0]  cur_min = '0;
    logic [5:0]  cur_hour = '0;
    logic [5:0]  cur_day = '0;
    logic [4:0]  cur_mon = '0;
    logic [11:0] cur_year = '0;
    logic        alarm_irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    rtc_alarm_cmp u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .sec_tick(sec_tick), .cur_sec(cur_sec), .cur_min(cur_min),
        .cur_hour(cur_hour), .cur_day(cur_day), .cur_mon(cur_mon),
        .cur_year(cur_year), .alarm_irq(alarm_irq)
    );

    task automatic chk(input string req, input string what, input int got, input int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s %s: got 0x%0h expected 0x%0h", req, what, got, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_en = 1'b1; addr = 3'(a); wdata = 12'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, output int v);
        addr = 3'(a);
        #1;
        v = int'(rdata);
    endtask

    task automatic set_time(input int s, input int m, input int h,
                            input int d, input int mo, input int y);
        cur_sec = 7'(s); cur_min = 7'(m); cur_hour = 6'(h);
        cur_day = 6'(d); cur_mon = 5'(mo); cur_year = 12'(y);
    endtask

    task automatic tick(input int s, input int m, input int h,
                        input int d, input int mo, input int y);
        @(negedge clk);
        set_time(s, m, h, d, mo, y);
        sec_tick = 1'b1;
        @(negedge clk);
        sec_tick = 1'b0;
    endtask

    task automatic t_reset();
        int v;
        for (int a = 0; a < 8; a++) begin
            rd(a, v);
            chk("R1", $sformatf("reg %0d after reset", a), v, 0);
        end
        chk("R1", "irq after reset", int'(alarm_irq), 0);
    endtask

    task automatic t_mask();
        int v;
        int exp_m[6] = '{'h7F, 'h7F, 'h3F, 'h3F, 'h1F, 'hFFF};
        for (int i = 0; i < 6; i++) begin
            wr(2 + i, 'hFFF);
            rd(2 + i, v);
            chk("R2", $sformatf("masked field %0d", i), v, exp_m[i]);
        end
        wr(0, 'hFFF);
        rd(0, v);
        chk("R3", "control keeps 7 bits", v, 'h7F);
        chk("R3", "no fire from writes", int'(alarm_irq), 0);
    endtask

    task automatic t_each_field();
        int v;
        for (int i = 0; i < 6; i++) begin
            wr(0, 'h40 | (1 << i));
            wr(2 + i, 'h12);
            tick(0, 0, 0, 0, 0, 0);
            chk("R3", $sformatf("field %0d mismatch", i), int'(alarm_irq), 0);
            case (i)
                0: tick('h12, 0, 0, 0, 0, 0);
                1: tick(0, 'h12, 0, 0, 0, 0);
                2: tick(0, 0, 'h12, 0, 0, 0);
                3: tick(0, 0, 0, 'h12, 0, 0);
                4: tick(0, 0, 0, 0, 'h12, 0);
                default: tick(0, 0, 0, 0, 0, 'h12);
            endcase
            chk("R3", $sformatf("field %0d enable bit fires", i), int'(alarm_irq), 1);
            wr(1, 'h2);
            chk("R10", "cleared between fields", int'(alarm_irq), 0);
        end
    endtask

    task automatic t_global_off();
        int v;
        wr(0, 'h01);
        wr(2, 'h30);
        tick('h30, 0, 0, 0, 0, 0);
        chk("R4", "no fire with master clear", int'(alarm_irq), 0);
        rd(1, v);
        chk("R4", "pending stays clear", v, 0);
    endtask

    task automatic t_no_tick_then_fire();
        int v;
        wr(0, 'h41);
        @(negedge clk);
        set_time('h30, 0, 0, 0, 0, 0);
        repeat (3) @(negedge clk);
        chk("R7", "match without strobe", int'(alarm_irq), 0);
        tick('h30, 0, 0, 0, 0, 0);
        chk("R8", "irq after strobe edge", int'(alarm_irq), 1);
        rd(1, v);
        chk("R8", "pending bit 1 set", v, 'h2);
    endtask

    task automatic t_hold();
        tick('h31, 0, 0, 0, 0, 0);
        tick('h32, 0, 0, 0, 0, 0);
        repeat (4) @(negedge clk);
        chk("R9", "level held without match", int'(alarm_irq), 1);
    endtask

    task automatic t_w1c();
        int v;
        wr(1, 'hFFD);
        chk("R10", "write with bit 1 clear ignored", int'(alarm_irq), 1);
        rd(1, v);
        chk("R10", "pending kept", v, 'h2);
        wr(1, 'h2);
        chk("R10", "write one clears irq", int'(alarm_irq), 0);
        rd(1, v);
        chk("R10", "pending cleared", v, 0);
    endtask

    task automatic t_or();
        wr(0, 'h43);
        wr(2, 'h30);
        wr(3, 'h15);
        tick('h05, 'h15, 0, 0, 0, 0);
        chk("R5", "one enabled match fires", int'(alarm_irq), 1);
        wr(1, 'h2);
    endtask

    task automatic t_disabled_field();
        wr(0, 'h41);
        tick('h05, 'h15, 0, 0, 0, 0);
        chk("R6", "disabled minutes match ignored", int'(alarm_irq), 0);
    endtask

    task automatic t_year();
        wr(0, 'h60);
        wr(7, 'h123);
        tick(0, 0, 0, 0, 0, 'h023);
        chk("R12", "hundreds digit differs", int'(alarm_irq), 0);
        tick(0, 0, 0, 0, 0, 'h124);
        chk("R12", "low digits differ", int'(alarm_irq), 0);
        tick(0, 0, 0, 0, 0, 'h123);
        chk("R12", "three digits equal", int'(alarm_irq), 1);
        wr(1, 'h2);
    endtask

    task automatic t_collide();
        wr(0, 'h41);
        wr(2, 'h30);
        tick('h30, 0, 0, 0, 0, 0);
        chk("R11", "pre-fire", int'(alarm_irq), 1);
        @(negedge clk);
        set_time('h30, 0, 0, 0, 0, 0);
        sec_tick = 1'b1; wr_en = 1'b1; addr = 3'd1; wdata = 12'h2;
        @(negedge clk);
        sec_tick = 1'b0; wr_en = 1'b0;
        chk("R11", "fire beats clear", int'(alarm_irq), 1);
        wr(1, 'h2);
        chk("R11", "later clear works", int'(alarm_irq), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_mask();
        t_each_field();
        t_global_off();
        t_no_tick_then_fire();
        t_hold();
        t_w1c();
        t_or();
        t_disabled_field();
        t_year();
        t_collide();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule